// File: doc/BRIEF.md
# Job Ring Slot Accounting Controller

This block keeps the books for two circular rings that software and a hardware engine share. The input ring carries jobs from software to the engine. The output ring carries completion records back to software. Software never writes pointers. Instead it reports how many jobs it has queued and how many results it has taken away, and it does so by writing counts. The engine reports its own progress with single-cycle pulses: one for each input entry it consumes and one for each output entry it produces. From these two sources the block keeps four values: the free-slot count of the input ring, the occupied-slot count of the output ring, the index the engine reads next, and the index the engine writes next.

The block checks every count that software writes. A request that would overrun a ring is refused and recorded in a write-1-to-clear status word. Completion interrupts can be merged: the flag can fire after a set number of completions, or when a prescaled timer expires. A ring-reset command first waits for the engine to go idle. It then clears both rings and loads ring sizes that software programmed earlier. All ports carry plain control and status signals. There is no valid/ready stream, because no data payload passes through the block.

Top module: `jr_slot_ctrl`

## Requirements
- R1: A ring size written on `in_size_wr`/`out_size_wr` is held aside and becomes active (`in_size`/`out_size`) only when a ring reset completes. After `rst_n` both sizes are `DEF_SIZE` (8), `in_avail` equals the input size, and `out_full`, `in_rd_idx`, `out_wr_idx` and `int_status` are zero.
- R2: A write on `jobs_add_wr` lowers `in_avail` by `jobs_cnt`. Each accepted `hw_consume` raises `in_avail` by one and advances `in_rd_idx`, which wraps to 0 after the value size-1.
- R3: Each accepted `hw_produce` raises `out_full` by one and advances `out_wr_idx`, which wraps at the output size. A write on `jobs_rmv_wr` lowers `out_full` by `jobs_cnt`.
- R4: An add larger than `in_avail` is not applied: it sets the error flag (`int_status` bit 1) and writes error type 9 into bits 11:8. A remove larger than `out_full` is handled the same way with type 8. When both happen in one cycle, type 9 wins.
- R5: `hw_consume` while `in_avail` equals the input size (no job queued), or `hw_produce` while `out_full` equals the output size, changes neither count nor index and sets `hw_fault`. `hw_fault` stays set until the next ring reset completes.
- R6: The `sts_w1c` bits act as follows: bit 0 clears the completion flag, bit 1 clears the error flag and the error type, and bit 2 or bit 3 returns a completed halt to 00. In each case a new set event in the same cycle takes priority over the clear. `irq` is (completion flag OR error flag) AND NOT mask (config bit 0).
- R7: With coalescing off (config bit 1 = 0), every accepted `hw_produce` sets the completion flag on the next cycle.
- R8: With coalescing on, the flag sets on the accepted produce that brings the completions pending since the last firing up to the count threshold (config bits 15:8, where 0 acts as 1). The pending count then starts again from zero.
- R9: With coalescing on and a nonzero timer threshold T (config bits 31:16), the flag sets exactly `TICK_DIV`*T cycles after the first pending completion, provided the count threshold has not fired first.
- R10: `ring_reset_req` moves the halt field (`int_status` bits 3:2) to 01. The field stays at 01 for as long as `hw_busy` is high. In the first cycle with `hw_busy` low the field moves to 10, both indices and `out_full` clear, and `in_avail` loads the new input size. `hw_enable` is low whenever the halt field is not 00.
- R11: With stop-on-error (config bit 2) set and the error flag set, `hw_enable` is low. Engine pulses are then ignored and do not set `hw_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration: mask b0, coalesce b1, stop-on-error b2, count threshold 15:8, timer threshold 31:16 |
| cfg_q | output | 32 | Configuration readback |
| in_size_wr | input | 1 | Stage a new input ring size |
| out_size_wr | input | 1 | Stage a new output ring size |
| size_wdata | input | W | Size value for either staging strobe |
| in_size | output | W | Active input ring size |
| out_size | output | W | Active output ring size |
| jobs_add_wr | input | 1 | Software added `jobs_cnt` jobs |
| jobs_rmv_wr | input | 1 | Software removed `jobs_cnt` results |
| jobs_cnt | input | W | Count for add/remove writes |
| sts_w1c_wr | input | 1 | Status clear strobe |
| sts_w1c | input | 4 | Write-1-to-clear mask for status bits 3:0 |
| ring_reset_req | input | 1 | Command: request ring reset |
| hw_consume | input | 1 | Engine consumed one input entry |
| hw_produce | input | 1 | Engine produced one output entry |
| hw_busy | input | 1 | Engine has an operation outstanding |
| hw_enable | output | 1 | Engine may issue consume/produce |
| in_avail | output | W | Input ring free slots |
| out_full | output | W | Output ring occupied slots |
| in_rd_idx | output | W | Next input index the engine reads |
| out_wr_idx | output | W | Next output index the engine writes |
| int_status | output | 32 | Status word: type 11:8, halt 3:2, error 1, completion 0 |
| irq | output | 1 | Interrupt request |
| hw_fault | output | 1 | Sticky engine-side protocol fault |

## Verification
The assertions rely on a few assumptions about the inputs. Ring sizes are assumed nonzero. The thresholds are assumed to change only while no completions are pending. The engine is assumed to pulse `hw_consume` and `hw_produce` for one cycle only, and to hold `hw_busy` low once it has no operation outstanding. The stimulus keeps to these assumptions in three ways. It stages only sizes of 4 to 6 and always follows a staging with a ring reset. It performs a ring reset before every configuration change that alters thresholds. It drives each engine pulse for exactly one cycle and raises `hw_busy` only around a halt request.

// File: rtl/jrsa_pkg.sv
package jrsa_pkg;
  typedef enum logic [1:0] {
    HALT_NONE = 2'b00,
    HALT_BUSY = 2'b01,
    HALT_DONE = 2'b10
  } halt_e;

  localparam logic [3:0] ERR_RMV_OVF = 4'd8;
  localparam logic [3:0] ERR_ADD_OVF = 4'd9;

  typedef struct packed {
    logic [15:0] tmr_thr;
    logic [7:0]  cnt_thr;
    logic [4:0]  spare;
    logic        stop_on_err;
    logic        coal_en;
    logic        irq_mask;
  } cfg_t;
endpackage

// File: rtl/jrsa_ring.sv
module jrsa_ring #(
  parameter int W           = 10,
  parameter int DEF_SIZE    = 8,
  parameter bit FILL_ON_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] size_next,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_cnt,
  input  logic         hw_op,
  input  logic         hw_en,
  output logic [W-1:0] size,
  output logic [W-1:0] level,
  output logic [W-1:0] idx,
  output logic         sw_err,
  output logic         hw_done,
  output logic         hw_err
);
  localparam logic [W-1:0] DEF_SZ  = W'(DEF_SIZE);
  localparam logic [W-1:0] DEF_LVL = FILL_ON_CLR ? DEF_SZ : '0;

  logic         room;
  logic         sw_ok;
  logic [W:0]   level_n;

  assign room    = level < size;
  assign hw_done = hw_op && hw_en && room;
  assign hw_err  = hw_op && hw_en && !room;
  assign sw_ok   = sw_wr && (sw_cnt <= level);
  assign sw_err  = sw_wr && (sw_cnt > level);
  assign level_n = {1'b0, level} - (sw_ok ? {1'b0, sw_cnt} : '0) + {{W{1'b0}}, hw_done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size  <= DEF_SZ;
      level <= DEF_LVL;
      idx   <= '0;
    end else if (clr) begin
      size  <= size_next;
      level <= FILL_ON_CLR ? size_next : '0;
      idx   <= '0;
    end else begin
      level <= level_n[W-1:0];
      if (hw_done) idx <= (idx == size - 1'b1) ? '0 : idx + 1'b1;
    end
  end

  a_r5_level_le_size: assert property (@(posedge clk) disable iff (!rst_n)
    level <= size);
  a_r2_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (size != '0) |-> (idx < size));
  a_r5_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_op && hw_en && level == size && !sw_wr && !clr) |=> $stable(level) && $stable(idx));
  a_r10_clr_zero_idx: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0));
endmodule

// File: rtl/jrsa_coalesce.sv
module jrsa_coalesce #(
  parameter int CNT_W    = 8,
  parameter int TMR_W    = 16,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             done,
  input  logic [CNT_W-1:0] cnt_thr,
  input  logic [TMR_W-1:0] tmr_thr,
  output logic             fire
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic [PW-1:0]    presc;
  logic             tick, cnt_hit, tmr_hit;
  logic [CNT_W:0]   cnt_lim;

  assign cnt_lim = (cnt_thr == '0) ? (CNT_W+1)'(1) : {1'b0, cnt_thr};
  assign tick    = (cnt != '0) && (presc == PLAST);
  assign cnt_hit = done && (({1'b0, cnt} + 1'b1) >= cnt_lim);
  assign tmr_hit = (tmr_thr != '0) && tick && (({1'b0, tmr} + 1'b1) >= {1'b0, tmr_thr});
  assign fire    = en ? (cnt_hit || tmr_hit) : done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; tmr <= '0; presc <= '0;
    end else if (clr || !en || cnt_hit || tmr_hit) begin
      cnt <= '0; tmr <= '0; presc <= '0;
    end else begin
      if (done) cnt <= cnt + 1'b1;
      if (done && cnt == '0) begin
        tmr   <= '0;
        presc <= '0;
      end else if (cnt != '0) begin
        if (tick) begin
          presc <= '0;
          tmr   <= tmr + 1'b1;
        end else begin
          presc <= presc + 1'b1;
        end
      end
    end
  end

  a_r9_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (tmr == '0 && presc == '0));
endmodule

// File: rtl/jr_slot_ctrl.sv
module jr_slot_ctrl
  import jrsa_pkg::*;
#(
  parameter int W        = 10,
  parameter int DEF_SIZE = 8,
  parameter int TICK_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [31:0]  cfg_wdata,
  output logic [31:0]  cfg_q,
  input  logic         in_size_wr,
  input  logic         out_size_wr,
  input  logic [W-1:0] size_wdata,
  output logic [W-1:0] in_size,
  output logic [W-1:0] out_size,
  input  logic         jobs_add_wr,
  input  logic         jobs_rmv_wr,
  input  logic [W-1:0] jobs_cnt,
  input  logic         sts_w1c_wr,
  input  logic [3:0]   sts_w1c,
  input  logic         ring_reset_req,
  input  logic         hw_consume,
  input  logic         hw_produce,
  input  logic         hw_busy,
  output logic         hw_enable,
  output logic [W-1:0] in_avail,
  output logic [W-1:0] out_full,
  output logic [W-1:0] in_rd_idx,
  output logic [W-1:0] out_wr_idx,
  output logic [31:0]  int_status,
  output logic         irq,
  output logic         hw_fault
);
  localparam logic [W-1:0] DEF_SZ = W'(DEF_SIZE);

  cfg_t        cfg;
  halt_e       halt;
  logic [W-1:0] in_size_pend, out_size_pend;
  logic        ring_clr;
  logic        add_err, rmv_err, in_hw_err, out_hw_err;
  logic        in_done, out_done, fire;
  logic        cmp_flag, err_flag;
  logic [3:0]  err_type;

  assign ring_clr  = (halt == HALT_BUSY) && !hw_busy;
  assign hw_enable = (halt == HALT_NONE) && !(cfg.stop_on_err && err_flag);
  assign cfg_q     = cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg           <= '0;
      in_size_pend  <= DEF_SZ;
      out_size_pend <= DEF_SZ;
    end else begin
      if (cfg_wr)      cfg           <= cfg_t'(cfg_wdata);
      if (in_size_wr)  in_size_pend  <= size_wdata;
      if (out_size_wr) out_size_pend <= size_wdata;
    end
  end

  jrsa_ring #(.W(W), .DEF_SIZE(DEF_SIZE), .FILL_ON_CLR(1'b1)) u_in_ring (
    .clk(clk), .rst_n(rst_n), .clr(ring_clr), .size_next(in_size_pend),
    .sw_wr(jobs_add_wr), .sw_cnt(jobs_cnt), .hw_op(hw_consume), .hw_en(hw_enable),
    .size(in_size), .level(in_avail), .idx(in_rd_idx),
    .sw_err(add_err), .hw_done(in_done), .hw_err(in_hw_err));

  jrsa_ring #(.W(W), .DEF_SIZE(DEF_SIZE), .FILL_ON_CLR(1'b0)) u_out_ring (
    .clk(clk), .rst_n(rst_n), .clr(ring_clr), .size_next(out_size_pend),
    .sw_wr(jobs_rmv_wr), .sw_cnt(jobs_cnt), .hw_op(hw_produce), .hw_en(hw_enable),
    .size(out_size), .level(out_full), .idx(out_wr_idx),
    .sw_err(rmv_err), .hw_done(out_done), .hw_err(out_hw_err));

  jrsa_coalesce #(.CNT_W(8), .TMR_W(16), .TICK_DIV(TICK_DIV)) u_coal (
    .clk(clk), .rst_n(rst_n), .clr(ring_clr), .en(cfg.coal_en), .done(out_done),
    .cnt_thr(cfg.cnt_thr), .tmr_thr(cfg.tmr_thr), .fire(fire));

  // Status flags, error type, sticky fault and halt sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_flag <= 1'b0;
      err_flag <= 1'b0;
      err_type <= '0;
      hw_fault <= 1'b0;
      halt     <= HALT_NONE;
    end else begin
      if (fire)                           cmp_flag <= 1'b1;
      else if (sts_w1c_wr && sts_w1c[0])  cmp_flag <= 1'b0;

      if (add_err) begin
        err_flag <= 1'b1;
        err_type <= ERR_ADD_OVF;
      end else if (rmv_err) begin
        err_flag <= 1'b1;
        err_type <= ERR_RMV_OVF;
      end else if (sts_w1c_wr && sts_w1c[1]) begin
        err_flag <= 1'b0;
        err_type <= '0;
      end

      if (ring_clr)                       hw_fault <= 1'b0;
      else if (in_hw_err || out_hw_err)   hw_fault <= 1'b1;

      unique case (halt)
        HALT_NONE: if (ring_reset_req) halt <= HALT_BUSY;
        HALT_BUSY: if (!hw_busy)       halt <= HALT_DONE;
        HALT_DONE: if (sts_w1c_wr && (sts_w1c[3] || sts_w1c[2])) halt <= HALT_NONE;
        default:                       halt <= HALT_NONE;
      endcase
    end
  end

  assign int_status = {20'b0, err_type, 4'b0, halt, err_flag, cmp_flag};
  assign irq        = (cmp_flag || err_flag) && !cfg.irq_mask;

  a_r10_halt_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (halt == HALT_BUSY && hw_busy) |=> (halt == HALT_BUSY));
  a_r4_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (err_type == ERR_ADD_OVF || err_type == ERR_RMV_OVF));
  a_r4_no_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (jobs_add_wr && jobs_cnt > in_avail && !ring_clr && !in_done) |=> $stable(in_avail));
endmodule

// File: tb/test_jr_slot_ctrl.sv
`timescale 1ns/1ps
module test_jr_slot_ctrl;
  localparam int W = 10;
  localparam int TD = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr; logic [31:0] cfg_wdata; logic [31:0] cfg_q;
  logic in_size_wr, out_size_wr; logic [W-1:0] size_wdata, in_size, out_size;
  logic jobs_add_wr, jobs_rmv_wr; logic [W-1:0] jobs_cnt;
  logic sts_w1c_wr; logic [3:0] sts_w1c;
  logic ring_reset_req, hw_consume, hw_produce, hw_busy, hw_enable;
  logic [W-1:0] in_avail, out_full, in_rd_idx, out_wr_idx;
  logic [31:0] int_status; logic irq, hw_fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  jr_slot_ctrl #(.W(W), .DEF_SIZE(8), .TICK_DIV(TD)) i_jr_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .in_size_wr(in_size_wr), .out_size_wr(out_size_wr), .size_wdata(size_wdata),
    .in_size(in_size), .out_size(out_size), .jobs_add_wr(jobs_add_wr),
    .jobs_rmv_wr(jobs_rmv_wr), .jobs_cnt(jobs_cnt), .sts_w1c_wr(sts_w1c_wr),
    .sts_w1c(sts_w1c), .ring_reset_req(ring_reset_req), .hw_consume(hw_consume),
    .hw_produce(hw_produce), .hw_busy(hw_busy), .hw_enable(hw_enable),
    .in_avail(in_avail), .out_full(out_full), .in_rd_idx(in_rd_idx),
    .out_wr_idx(out_wr_idx), .int_status(int_status), .irq(irq), .hw_fault(hw_fault));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic w_cfg(input logic [31:0] v);
    cfg_wdata = v; cfg_wr = 1'b1; step(); cfg_wr = 1'b0;
  endtask
  task automatic add_jobs(input int n);
    jobs_cnt = W'(n); jobs_add_wr = 1'b1; step(); jobs_add_wr = 1'b0;
  endtask
  task automatic rmv_jobs(input int n);
    jobs_cnt = W'(n); jobs_rmv_wr = 1'b1; step(); jobs_rmv_wr = 1'b0;
  endtask
  task automatic consume();
    hw_consume = 1'b1; step(); hw_consume = 1'b0;
  endtask
  task automatic produce();
    hw_produce = 1'b1; step(); hw_produce = 1'b0;
  endtask
  task automatic clear(input logic [3:0] m);
    sts_w1c = m; sts_w1c_wr = 1'b1; step(); sts_w1c_wr = 1'b0; sts_w1c = '0;
  endtask
  task automatic ring_reset();
    ring_reset_req = 1'b1; step(); ring_reset_req = 1'b0;
    step();
    clear(4'hB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr = 0; cfg_wdata = 0; in_size_wr = 0; out_size_wr = 0; size_wdata = 0;
    jobs_add_wr = 0; jobs_rmv_wr = 0; jobs_cnt = 0; sts_w1c_wr = 0; sts_w1c = 0;
    ring_reset_req = 0; hw_consume = 0; hw_produce = 0; hw_busy = 0;
    step(3); rst_n = 1'b1; step();

    // R1 reset state
    chk("R1 reset in_size", 32'(in_size), 8);
    chk("R1 reset in_avail", 32'(in_avail), 8);
    chk("R1 reset out_full", 32'(out_full), 0);
    chk("R1 reset status", int_status, 0);
    chk("R1 reset irq/enable", {30'b0, irq, hw_enable}, 1);

    // R1 staged sizes take effect at reset completion
    size_wdata = 5; in_size_wr = 1'b1; step(); in_size_wr = 1'b0;
    size_wdata = 6; out_size_wr = 1'b1; step(); out_size_wr = 1'b0;
    chk("R1 staged size not yet active", 32'(in_size), 8);
    ring_reset();
    chk("R1 in_size after reset", 32'(in_size), 5);
    chk("R1 out_size after reset", 32'(out_size), 6);
    chk("R1 in_avail reloaded", 32'(in_avail), 5);

    // R2 / R4 / R5: sweep add counts on a 5-entry input ring
    for (int n = 0; n <= 7; n++) begin
      int q;
      ring_reset();
      add_jobs(n);
      q = (n <= 5) ? n : 0;
      chk($sformatf("R2 avail after add %0d", n), 32'(in_avail), 32'(5 - q));
      chk($sformatf("R4 err type after add %0d", n), 32'(int_status[11:8]), (n > 5) ? 9 : 0);
      chk($sformatf("R4 err flag after add %0d", n), 32'(int_status[1]), (n > 5) ? 1 : 0);
      for (int k = 0; k <= n; k++) consume();
      chk($sformatf("R2 rd idx after %0d consumes", q), 32'(in_rd_idx), 32'(q % 5));
      chk($sformatf("R2 avail restored n=%0d", n), 32'(in_avail), 5);
      chk($sformatf("R5 fault after extra consume n=%0d", n), 32'(hw_fault), 1);
    end

    // R3 / R5: fill the 6-entry output ring one entry at a time, then one more
    ring_reset();
    chk("R5 fault cleared by ring reset", 32'(hw_fault), 0);
    for (int p = 1; p <= 7; p++) begin
      int f;
      produce();
      f = (p < 6) ? p : 6;
      chk($sformatf("R3 full after %0d produces", p), 32'(out_full), 32'(f));
      chk($sformatf("R3 wr idx after %0d produces", p), 32'(out_wr_idx), 32'(f % 6));
    end
    chk("R5 fault on produce into full ring", 32'(hw_fault), 1);
    rmv_jobs(7);
    chk("R4 remove overflow type", 32'(int_status[11:8]), 8);
    chk("R4 remove overflow keeps full", 32'(out_full), 6);
    clear(4'h2);
    chk("R6 w1c bit1 clears error", 32'(int_status[11:0] & 12'hF02), 0);
    rmv_jobs(4);
    chk("R3 remove lowers full", 32'(out_full), 2);

    // R4 priority: add and remove overflow in the same cycle
    ring_reset();
    jobs_cnt = 7; jobs_add_wr = 1'b1; jobs_rmv_wr = 1'b1; step();
    jobs_add_wr = 1'b0; jobs_rmv_wr = 1'b0;
    chk("R4 add overflow wins", 32'(int_status[11:8]), 9);

    // R7 / R6: no coalescing, interrupt and mask
    ring_reset();
    produce();
    chk("R7 completion flag per produce", 32'(int_status[0]), 1);
    chk("R6 irq unmasked", 32'(irq), 1);
    clear(4'h1);
    chk("R6 w1c bit0 clears completion", 32'(int_status[0]), 0);
    w_cfg(32'h1);
    produce();
    chk("R6 masked irq low", {30'b0, irq, int_status[0]}, 1);

    // R8: count threshold 3
    ring_reset();
    w_cfg((32'd3 << 8) | 32'h2);
    produce(); produce();
    chk("R8 below count threshold", 32'(int_status[0]), 0);
    produce();
    chk("R8 at count threshold", 32'(int_status[0]), 1);
    clear(4'h1);
    produce();
    chk("R8 count restarts after fire", 32'(int_status[0]), 0);

    // R9: timer threshold 2 with large count threshold
    ring_reset();
    w_cfg((32'd2 << 16) | (32'd50 << 8) | 32'h2);
    produce();
    step(TD * 2 - 1);
    chk("R9 timer one cycle early", 32'(int_status[0]), 0);
    step();
    chk("R9 timer expiry", 32'(int_status[0]), 1);

    // R11: stop on error blocks the engine
    ring_reset();
    w_cfg(32'h4);
    add_jobs(2);
    add_jobs(9);
    chk("R11 enable low on error", 32'(hw_enable), 0);
    consume();
    chk("R11 consume ignored", 32'(in_avail), 3);
    chk("R11 no fault while stopped", 32'(hw_fault), 0);
    clear(4'h2);
    chk("R11 enable after clear", 32'(hw_enable), 1);
    consume();
    chk("R11 consume resumes", 32'(in_avail), 4);

    // R10 / R1: halt waits for engine idle
    w_cfg(32'h0);
    ring_reset();
    add_jobs(2); produce();
    size_wdata = 4; in_size_wr = 1'b1; step(); in_size_wr = 1'b0;
    hw_busy = 1'b1;
    ring_reset_req = 1'b1; step(); ring_reset_req = 1'b0;
    chk("R10 halt in progress", 32'(int_status[3:2]), 1);
    chk("R10 enable low while halting", 32'(hw_enable), 0);
    step(3);
    chk("R10 halt holds while busy", 32'(int_status[3:2]), 1);
    chk("R10 counts kept while busy", 32'(in_avail), 3);
    hw_busy = 1'b0; step();
    chk("R10 halt complete", 32'(int_status[3:2]), 2);
    chk("R10 avail reloaded with staged size", 32'(in_avail), 4);
    chk("R10 full cleared", 32'(out_full), 0);
    chk("R10 indices cleared", 32'({in_rd_idx, out_wr_idx}), 0);
    clear(4'h8);
    chk("R6 halt acknowledged", {29'b0, int_status[3:2], hw_enable}, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule